// File: doc/BRIEF.md
# Cross-Domain Mailbox Register Pair

This block holds two word-wide mailbox registers that carry single words between two independently clocked ports, one register for each direction. It sits beside a FIFO path. A mailbox-select input on each port steers that port's cycle to the mailbox instead of the FIFO. Port A writes the first mailbox (mail1) and reads the second (mail2). Port B writes mail2 and reads mail1. On port B the select also chooses what the data output shows: mail1 contents or the word supplied by the neighbouring FIFO output register.

Each mailbox has an active-low full flag. The writing port's clock drives it low when a word is stored. A mailbox read on the opposite port releases it. The release crosses into the writer's domain through a toggle request/acknowledge pair with two-flop synchronizers, so each flag is only ever updated by registers of the domain that sees it. While a flag is low, further writes to that mailbox are refused.

A port cycle is qualified by an active-low chip select, an active-high enable and a direction control (1 = write, 0 = read). These are sampled on the rising edge of that port's clock. Reset is asynchronous and active low.

Top module: `mbxPair`

## Requirements
- R1: A port-A cycle with csAN=0, enA=1, wrA=1, mbSelA=1 while mbf1N=1 stores dinA in mail1 on that clkA edge, and mbf1N is 0 right after that edge.
- R2: While mbf1N=0 a port-A mailbox write is refused: mail1 contents, as seen on doutB with mbSelB=1, keep the earlier word.
- R3: A port-B cycle with csBN=0, enB=1, wrB=0, mbSelB=1, made once the write has reached port B (two clkB edges after it), returns mbf1N to 1 by the second clkA edge after that clkB edge.
- R4: Mail2 mirrors mail1. A qualified port-B mailbox write stores dinB and drives mbf2N to 0. Further port-B writes are refused while mbf2N=0. doutA always shows mail2. A qualified port-A mailbox read (wrA=0, mbSelA=1) returns mbf2N to 1.
- R5: While rstN=0 both mbf1N and mbf2N are 1 and both mailboxes hold zero.
- R6: doutB shows mail1 when mbSelB=1 and fifoDataB when mbSelB=0.
- R7: A port-A cycle with csAN=1, with enA=0, with mbSelA=0, or with wrA=0 leaves mbf1N and mail1 unchanged.
- R8: A port-B read with mbSelB=0 or with enB=0 does not release mbf1N.
- R9: A port-A mailbox write held continuously across a release is accepted on the first clkA edge at which mbf1N is 1, storing the held word and driving mbf1N low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkA | input | 1 | Port-A clock |
| clkB | input | 1 | Port-B clock |
| rstN | input | 1 | Asynchronous active-low reset, both domains |
| csAN | input | 1 | Port-A chip select, active low |
| enA | input | 1 | Port-A enable |
| wrA | input | 1 | Port-A direction, 1 write / 0 read |
| mbSelA | input | 1 | Port-A mailbox select |
| dinA | input | WIDTH | Port-A write data |
| doutA | output | WIDTH | Mail2 contents |
| mbf1N | output | 1 | Mail1 full flag, active low, clkA domain |
| csBN | input | 1 | Port-B chip select, active low |
| enB | input | 1 | Port-B enable |
| wrB | input | 1 | Port-B direction, 1 write / 0 read |
| mbSelB | input | 1 | Port-B mailbox select and output steering |
| dinB | input | WIDTH | Port-B write data |
| fifoDataB | input | WIDTH | FIFO output register word from the neighbour |
| doutB | output | WIDTH | Mail1 or FIFO word, chosen by mbSelB |
| mbf2N | output | 1 | Mail2 full flag, active low, clkB domain |

## Verification
The release of mbf1N and a new port-A mailbox write can land on the same clkA edge. The acknowledge arriving through the synchronizer raises the flag, and a write that is already held is then taken on that edge. The bench provokes this by holding a port-A mailbox write with a fresh word asserted without a break while port B performs the releasing read. It judges the result by mbf1N being low again and doutB showing the fresh word, never the refused one.

// File: rtl/mbxPkg.sv
package mbxPkg;
  // Qualified strobes passed from control to datapath
  typedef struct packed {
    logic wr1;  // clkA: accepted mail1 write
    logic rd1;  // clkB: accepted mail1 read
    logic wr2;  // clkB: accepted mail2 write
    logic rd2;  // clkA: accepted mail2 read
  } mbxStrobe_t;
endpackage

// File: rtl/mbxSync.sv
module mbxSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mbxFlagChan.sv
module mbxFlagChan #(
  parameter int SYNC_STAGES = 2
) (
  input  logic wrClk,
  input  logic rdClk,
  input  logic rstN,
  input  logic wrReq,
  input  logic rdReq,
  output logic flagN,
  output logic wrTake,
  output logic rdTake
);
  logic reqT, ackT, reqSync, ackSync, pending;

  // writer domain: toggle request on each accepted write
  assign wrTake = wrReq && flagN;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN)       reqT <= 1'b0;
    else if (wrTake) reqT <= ~reqT;
  end

  mbxSync #(.STAGES(SYNC_STAGES)) ackSyncU (
    .clk(wrClk), .rstN(rstN), .d(ackT), .q(ackSync)
  );

  assign flagN = (reqT == ackSync);

  // reader domain: acknowledge one outstanding request per read
  mbxSync #(.STAGES(SYNC_STAGES)) reqSyncU (
    .clk(rdClk), .rstN(rstN), .d(reqT), .q(reqSync)
  );

  assign pending = (reqSync != ackT);
  assign rdTake  = rdReq && pending;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)       ackT <= 1'b0;
    else if (rdTake) ackT <= ~ackT;
  end
endmodule

// File: rtl/mbxCtrl.sv
module mbxCtrl
  import mbxPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clkA,
  input  logic       clkB,
  input  logic       rstN,
  input  logic       csAN,
  input  logic       enA,
  input  logic       wrA,
  input  logic       mbSelA,
  input  logic       csBN,
  input  logic       enB,
  input  logic       wrB,
  input  logic       mbSelB,
  output mbxStrobe_t strb,
  output logic       mbf1N,
  output logic       mbf2N
);
  logic mbCycA, mbCycB;
  logic rawWr1, rawRd1, rawWr2, rawRd2;
  logic take1Rd, take2Wr;

  assign mbCycA = !csAN && enA && mbSelA;
  assign mbCycB = !csBN && enB && mbSelB;

  assign rawWr1 = mbCycA &&  wrA;
  assign rawRd2 = mbCycA && !wrA;
  assign rawWr2 = mbCycB &&  wrB;
  assign rawRd1 = mbCycB && !wrB;

  // mail1: written from A, read from B
  mbxFlagChan #(.SYNC_STAGES(SYNC_STAGES)) chan1U (
    .wrClk(clkA), .rdClk(clkB), .rstN(rstN),
    .wrReq(rawWr1), .rdReq(rawRd1),
    .flagN(mbf1N), .wrTake(strb.wr1), .rdTake(take1Rd)
  );

  // mail2: written from B, read from A
  mbxFlagChan #(.SYNC_STAGES(SYNC_STAGES)) chan2U (
    .wrClk(clkB), .rdClk(clkA), .rstN(rstN),
    .wrReq(rawWr2), .rdReq(rawRd2),
    .flagN(mbf2N), .wrTake(take2Wr), .rdTake(strb.rd2)
  );

  assign strb.rd1 = take1Rd;
  assign strb.wr2 = take2Wr;
endmodule

// File: rtl/mbxData.sv
module mbxData
  import mbxPkg::*;
#(
  parameter int WIDTH = 36
) (
  input  logic             clkA,
  input  logic             clkB,
  input  logic             rstN,
  input  mbxStrobe_t       strb,
  input  logic [WIDTH-1:0] dinA,
  input  logic [WIDTH-1:0] dinB,
  input  logic [WIDTH-1:0] fifoDataB,
  input  logic             mbSelB,
  output logic [WIDTH-1:0] doutA,
  output logic [WIDTH-1:0] doutB,
  output logic [WIDTH-1:0] mail1Q,
  output logic [WIDTH-1:0] mail2Q
);
  always_ff @(posedge clkA or negedge rstN) begin
    if (!rstN)         mail1Q <= '0;
    else if (strb.wr1) mail1Q <= dinA;
  end

  always_ff @(posedge clkB or negedge rstN) begin
    if (!rstN)         mail2Q <= '0;
    else if (strb.wr2) mail2Q <= dinB;
  end

  assign doutA = mail2Q;
  assign doutB = mbSelB ? mail1Q : fifoDataB;
endmodule

// File: rtl/mbxPair.sv
module mbxPair
  import mbxPkg::*;
#(
  parameter int WIDTH       = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clkA,
  input  logic             clkB,
  input  logic             rstN,
  input  logic             csAN,
  input  logic             enA,
  input  logic             wrA,
  input  logic             mbSelA,
  input  logic [WIDTH-1:0] dinA,
  output logic [WIDTH-1:0] doutA,
  output logic             mbf1N,
  input  logic             csBN,
  input  logic             enB,
  input  logic             wrB,
  input  logic             mbSelB,
  input  logic [WIDTH-1:0] dinB,
  input  logic [WIDTH-1:0] fifoDataB,
  output logic [WIDTH-1:0] doutB,
  output logic             mbf2N
);
  mbxStrobe_t       strb;
  logic [WIDTH-1:0] mail1Q, mail2Q;

  mbxCtrl #(.SYNC_STAGES(SYNC_STAGES)) ctrlU (
    .clkA(clkA), .clkB(clkB), .rstN(rstN),
    .csAN(csAN), .enA(enA), .wrA(wrA), .mbSelA(mbSelA),
    .csBN(csBN), .enB(enB), .wrB(wrB), .mbSelB(mbSelB),
    .strb(strb), .mbf1N(mbf1N), .mbf2N(mbf2N)
  );

  mbxData #(.WIDTH(WIDTH)) dataU (
    .clkA(clkA), .clkB(clkB), .rstN(rstN), .strb(strb),
    .dinA(dinA), .dinB(dinB), .fifoDataB(fifoDataB), .mbSelB(mbSelB),
    .doutA(doutA), .doutB(doutB), .mail1Q(mail1Q), .mail2Q(mail2Q)
  );
endmodule

// File: rtl/mbxPairChk.sv
module mbxPairChk #(
  parameter int WIDTH = 36
) (
  input logic             clkA,
  input logic             clkB,
  input logic             rstN,
  input logic             csAN,
  input logic             enA,
  input logic             wrA,
  input logic             mbSelA,
  input logic [WIDTH-1:0] dinA,
  input logic             csBN,
  input logic             enB,
  input logic             wrB,
  input logic             mbSelB,
  input logic [WIDTH-1:0] dinB,
  input logic             mbf1N,
  input logic             mbf2N,
  input logic [WIDTH-1:0] mail1,
  input logic [WIDTH-1:0] mail2
);
  // R1
  mail1_set_chk: assert property (@(posedge clkA) disable iff (!rstN)
    (!csAN && enA && wrA && mbSelA && mbf1N) |=> (!mbf1N && mail1 == $past(dinA)));

  // R2
  mail1_hold_chk: assert property (@(posedge clkA) disable iff (!rstN)
    !mbf1N |=> $stable(mail1));

  // R4
  mail2_set_chk: assert property (@(posedge clkB) disable iff (!rstN)
    (!csBN && enB && wrB && mbSelB && mbf2N) |=> (!mbf2N && mail2 == $past(dinB)));

  // R4
  mail2_hold_chk: assert property (@(posedge clkB) disable iff (!rstN)
    !mbf2N |=> $stable(mail2));

  // R7
  mbf1_fall_chk: assert property (@(posedge clkA) disable iff (!rstN)
    $fell(mbf1N) |-> $past(!csAN && enA && wrA && mbSelA));

  // R5
  reset_flags_chk: assert property (@(posedge clkA)
    !rstN |-> (mbf1N && mbf2N && mail1 == '0 && mail2 == '0));
endmodule

bind mbxPair mbxPairChk #(.WIDTH(WIDTH)) chkU (
  .clkA(clkA), .clkB(clkB), .rstN(rstN),
  .csAN(csAN), .enA(enA), .wrA(wrA), .mbSelA(mbSelA), .dinA(dinA),
  .csBN(csBN), .enB(enB), .wrB(wrB), .mbSelB(mbSelB), .dinB(dinB),
  .mbf1N(mbf1N), .mbf2N(mbf2N), .mail1(mail1Q), .mail2(mail2Q)
);

// File: tb/mbxPair_test.sv
module mbxPair_test;
  localparam int W = 36;
  localparam time CLK_A_PERIOD = 10ns;
  localparam time CLK_B_PERIOD = 14ns;

  logic clkA = 1'b0, clkB = 1'b0, rstN = 1'b0;
  logic csAN = 1'b1, enA = 1'b0, wrA = 1'b0, mbSelA = 1'b0;
  logic csBN = 1'b1, enB = 1'b0, wrB = 1'b0, mbSelB = 1'b1;
  logic [W-1:0] dinA = '0, dinB = '0, fifoDataB = '0;
  logic [W-1:0] doutA, doutB;
  logic mbf1N, mbf2N;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #(CLK_A_PERIOD/2) clkA = ~clkA;
  always #(CLK_B_PERIOD/2) clkB = ~clkB;

  mbxPair #(.WIDTH(W)) uut (
    .clkA(clkA), .clkB(clkB), .rstN(rstN),
    .csAN(csAN), .enA(enA), .wrA(wrA), .mbSelA(mbSelA), .dinA(dinA),
    .doutA(doutA), .mbf1N(mbf1N),
    .csBN(csBN), .enB(enB), .wrB(wrB), .mbSelB(mbSelB), .dinB(dinB),
    .fifoDataB(fifoDataB), .doutB(doutB), .mbf2N(mbf2N)
  );

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitA(int n);
    repeat (n) @(negedge clkA);
  endtask

  task automatic waitB(int n);
    repeat (n) @(negedge clkB);
  endtask

  // one port-A cycle, then back to idle
  task automatic cycA(logic cs, logic en, logic wr, logic mb, logic [W-1:0] d);
    @(negedge clkA);
    csAN = cs; enA = en; wrA = wr; mbSelA = mb; dinA = d;
    @(negedge clkA);
    csAN = 1'b1; enA = 1'b0; wrA = 1'b0; mbSelA = 1'b0;
  endtask

  // one port-B cycle, then back to idle with output steered to mail1
  task automatic cycB(logic cs, logic en, logic wr, logic mb, logic [W-1:0] d);
    @(negedge clkB);
    csBN = cs; enB = en; wrB = wr; mbSelB = mb; dinB = d;
    @(negedge clkB);
    csBN = 1'b1; enB = 1'b0; wrB = 1'b0; mbSelB = 1'b1;
  endtask

  task automatic testReset();
    check("R5 mbf1N in reset", W'(mbf1N), W'(1));
    check("R5 mbf2N in reset", W'(mbf2N), W'(1));
    check("R5 mail2 in reset", doutA, '0);
  endtask

  task automatic testQualifiers();
    cycA(1'b1, 1'b1, 1'b1, 1'b1, 36'hA_AAAA_0001);  // chip select high
    cycA(1'b0, 1'b0, 1'b1, 1'b1, 36'hA_AAAA_0002);  // enable low
    cycA(1'b0, 1'b1, 1'b1, 1'b0, 36'hA_AAAA_0003);  // FIFO write
    cycA(1'b0, 1'b1, 1'b0, 1'b1, 36'hA_AAAA_0004);  // read, not write
    waitA(1);
    check("R7 mbf1N after unqualified cycles", W'(mbf1N), W'(1));
    check("R7 mail1 after unqualified cycles", doutB, '0);
  endtask

  task automatic testWriteAndMux();
    cycA(1'b0, 1'b1, 1'b1, 1'b1, 36'h1_2345_6789);
    check("R1 mbf1N after write", W'(mbf1N), W'(0));
    waitB(1);
    check("R1/R6 doutB mailbox view", doutB, 36'h1_2345_6789);
    fifoDataB = 36'hF_0F0F_0F0F;
    mbSelB = 1'b0;
    waitB(1);
    check("R6 doutB FIFO view", doutB, 36'hF_0F0F_0F0F);
    mbSelB = 1'b1;
    waitB(1);
  endtask

  task automatic testBlocked();
    cycA(1'b0, 1'b1, 1'b1, 1'b1, 36'hB_BBBB_BBBB);
    waitB(1);
    check("R2 mail1 kept while full", doutB, 36'h1_2345_6789);
    check("R2 mbf1N still low", W'(mbf1N), W'(0));
  endtask

  task automatic testNoRelease();
    waitB(3);
    cycB(1'b0, 1'b1, 1'b0, 1'b0, '0);  // FIFO read
    cycB(1'b0, 1'b0, 1'b0, 1'b1, '0);  // disabled mailbox read
    waitA(6);
    check("R8 mbf1N not released", W'(mbf1N), W'(0));
  endtask

  task automatic testRelease();
    cycB(1'b0, 1'b1, 1'b0, 1'b1, '0);
    waitA(4);
    check("R3 mbf1N released", W'(mbf1N), W'(1));
  endtask

  // release and a held write meet on the same clkA edge
  task automatic testHeldWrite();
    cycA(1'b0, 1'b1, 1'b1, 1'b1, 36'h0_5555_0001);
    waitB(3);
    @(negedge clkA);
    csAN = 1'b0; enA = 1'b1; wrA = 1'b1; mbSelA = 1'b1; dinA = 36'h0_5555_0002;
    cycB(1'b0, 1'b1, 1'b0, 1'b1, '0);
    waitA(8);
    csAN = 1'b1; enA = 1'b0; wrA = 1'b0; mbSelA = 1'b0;
    check("R9 mbf1N low after held write", W'(mbf1N), W'(0));
    waitB(1);
    check("R9 held word stored", doutB, 36'h0_5555_0002);
  endtask

  task automatic testMail2();
    cycB(1'b0, 1'b1, 1'b1, 1'b1, 36'h7_6543_2100);
    check("R4 mbf2N after write", W'(mbf2N), W'(0));
    waitA(4);
    check("R4 doutA shows mail2", doutA, 36'h7_6543_2100);
    cycB(1'b0, 1'b1, 1'b1, 1'b1, 36'hC_CCCC_CCCC);
    waitA(2);
    check("R4 mail2 kept while full", doutA, 36'h7_6543_2100);
    cycA(1'b0, 1'b1, 1'b0, 1'b1, '0);
    waitB(4);
    check("R4 mbf2N released", W'(mbf2N), W'(1));
  endtask

  initial begin
    waitA(1);
    testReset();
    waitA(2);
    #3 rstN = 1'b1;
    waitA(3);
    testQualifiers();
    testWriteAndMux();
    testBlocked();
    testNoRelease();
    testRelease();
    testHeldWrite();
    testMail2();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clkA);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule